// File: doc/BRIEF.md
# Fuse-Backed Flash Encryption Enable Controller

This block models a small bank of one-time-programmable fuses that decides whether transparent flash encryption is active. The state it holds: a 3-bit boot encryption counter, a 4-bit purpose code for each of six key slots, a three-bit group of disable fuses, write-protect bits and read-protect bits. Every fuse reads 0 on a fresh part, and a burn can only turn a 0 into a 1. Encryption is on when the counter has an odd number of bits set, so each further advance of the counter switches it the other way. The counter therefore also limits how many plaintext reflash cycles are left.

Software burns a field by choosing a field code, giving a bit mask and pulsing a strobe. It reads any field through a separate select and data path. The encryption engine takes these outputs:
- the enable flag;
- the index of the key slot to use and a flag saying a slot qualifies;
- the count of plaintext reflashes still allowed;
- a flag that blocks encryption when the part boots in download mode.

Top module: `otp_crypt_ctrl`

## Requirements
- R1: After synchronous reset, every fuse is 0, `busy` is 0, `enc_en` and `key_valid` are 0, `key_slot` is 0 and `flashes_left` is 1.
- R2: A burn ORs the mask into the addressed field, so fuse bits only go from 0 to 1. Field codes are: 0 counter (mask bits 2:0), 1 counter advance (mask unused), 2+i purpose of key slot i for i=0..5 (mask bits 3:0), 8 disable group (mask bits 2:0), 9 write-protect (mask bits 7:0), 10 read-protect (mask bits 5:0). Codes 11 to 15 are ignored and read as 0.
- R3: `enc_en` is 1 when the counter has 1 or 3 bits set, and 0 when it has 0 or 2 bits set. Download blocking under R8 overrides this.
- R4: An advance (code 1) sets the lowest clear bit of the counter, giving 001, then 011, then 111. An advance of a full counter changes nothing.
- R5: A key slot qualifies when its purpose code equals 4. `key_slot` is the lowest-numbered qualifying slot and `key_valid` is 1. With no qualifying slot, `key_valid` is 0 and `key_slot` is 0.
- R6: Write-protect bit 0 covers the counter, bit 1+i covers slot i, and bit 7 covers all three disable fuses together. A burn to a protected field is ignored.
- R7: A read of a key slot whose read-protect bit i is set returns 0. Its purpose code still takes part in key selection.
- R8: Disable bit 0 is the download-mode manual encryption disable, and `dl_crypt_blocked` reflects it. While that bit is set and `dl_mode` is 1, `enc_en` is 0.
- R9: `flashes_left` is half the number of clear counter bits above the highest set bit, rounded down. It is 0 when counter write-protect is set.
- R10: A burn takes effect on the second rising edge after the strobe is sampled. `busy` is 1 for exactly the cycle between. Reads in that cycle return the old value, and a strobe seen while `busy` is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; returns fuses to the fresh-part state |
| burn_stb | input | 1 | Burn request strobe |
| burn_sel | input | 4 | Field code of the burn |
| burn_mask | input | 8 | Bits to burn, aligned to bit 0 of the field |
| rd_sel | input | 4 | Field code to read |
| rd_data | output | 8 | Read value, zero-extended |
| dl_mode | input | 1 | Part is in download boot mode |
| busy | output | 1 | A burn is pending |
| enc_en | output | 1 | Transparent flash encryption enabled |
| key_slot | output | 3 | Selected key slot index |
| key_valid | output | 1 | A slot with purpose 4 exists |
| flashes_left | output | 2 | Plaintext reflashes remaining |
| dl_crypt_blocked | output | 1 | Manual encryption disable fuse in download mode |

## Verification
The bench targets how the counter behaves as it fills. A design that tested for "any bit set" rather than odd parity would leave encryption on at 011. A design that counted all clear bits would report a reflash for a counter of 010 that has no upper room.

For key selection, the bench puts purpose 4 in two slots and then spoils the lower one. This catches a priority encoder that picks the wrong end or does not fall back.

Write-protect is checked on the counter, on single slots and on the grouped disable fuses; a group mapped to only one bit would let the other two be burned. The bench also sends a second strobe during `busy` and reads during the busy cycle. A design that queued the second strobe, or applied a burn one cycle early, shows up there.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

    parameter int CNT_W       = 3;
    parameter int N_SLOTS     = 6;
    parameter int PURP_W      = 4;
    parameter int KEY_PURPOSE = 4;
    parameter int DIS_W       = 3;
    parameter int MASK_W      = 8;
    parameter int FSEL_W      = 4;
    parameter int RD_W        = 8;

    localparam int SLOT_W   = $clog2(N_SLOTS);
    localparam int WP_W     = N_SLOTS + 2;
    localparam int FL_W     = $clog2(CNT_W + 1);
    localparam int WP_CNT   = 0;
    localparam int WP_KP0   = 1;
    localparam int WP_DIS   = N_SLOTS + 1;
    localparam int DIS_MANUAL = 0;

    localparam logic [FSEL_W-1:0] FSEL_CNT = FSEL_W'(0);
    localparam logic [FSEL_W-1:0] FSEL_ADV = FSEL_W'(1);
    localparam int                FSEL_KP0 = 2;
    localparam logic [FSEL_W-1:0] FSEL_DIS = FSEL_W'(FSEL_KP0 + N_SLOTS);
    localparam logic [FSEL_W-1:0] FSEL_WP  = FSEL_W'(FSEL_KP0 + N_SLOTS + 1);
    localparam logic [FSEL_W-1:0] FSEL_RP  = FSEL_W'(FSEL_KP0 + N_SLOTS + 2);

    typedef logic [N_SLOTS-1:0][PURP_W-1:0] purpose_arr_t;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        purpose_arr_t       kp;
        logic [DIS_W-1:0]   dis;
        logic [WP_W-1:0]    wp;
        logic [N_SLOTS-1:0] rp;
    } fuse_state_t;

    typedef struct packed {
        logic [FSEL_W-1:0] sel;
        logic [MASK_W-1:0] mask;
    } burn_req_t;

    function automatic logic [CNT_W-1:0] lowest_clear(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] r;
        r = '0;
        for (int i = CNT_W - 1; i >= 0; i--) begin
            if (!c[i]) r = CNT_W'(1) << i;
        end
        return r;
    endfunction

    function automatic logic [FL_W-1:0] plain_left(input logic [CNT_W-1:0] c);
        int top;
        top = -1;
        for (int i = 0; i < CNT_W; i++) begin
            if (c[i]) top = i;
        end
        return FL_W'((CNT_W - 1 - top) / 2);
    endfunction

endpackage

// File: rtl/otp_fuse_bank.sv
`timescale 1ns/1ps
module otp_fuse_bank
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burn_stb,
    input  logic [FSEL_W-1:0] burn_sel,
    input  logic [MASK_W-1:0] burn_mask,
    output logic              busy,
    output fuse_state_t       fuses
);

    burn_req_t   pend_q;
    logic        pend_v_q;
    fuse_state_t fuse_q;
    fuse_state_t fuse_d;
    logic        accept;

    assign accept = burn_stb && !pend_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q <= 1'b0;
            pend_q   <= '0;
        end else begin
            pend_v_q <= accept;
            if (accept) begin
                pend_q.sel  <= burn_sel;
                pend_q.mask <= burn_mask;
            end
        end
    end

    always_comb begin
        fuse_d = fuse_q;
        if (pend_v_q) begin
            if (pend_q.sel == FSEL_CNT && !fuse_q.wp[WP_CNT]) begin
                fuse_d.cnt = fuse_q.cnt | pend_q.mask[CNT_W-1:0];
            end
            if (pend_q.sel == FSEL_ADV && !fuse_q.wp[WP_CNT]) begin
                fuse_d.cnt = fuse_q.cnt | lowest_clear(fuse_q.cnt);
            end
            for (int i = 0; i < N_SLOTS; i++) begin
                if (pend_q.sel == FSEL_W'(FSEL_KP0 + i) && !fuse_q.wp[WP_KP0 + i]) begin
                    fuse_d.kp[i] = fuse_q.kp[i] | pend_q.mask[PURP_W-1:0];
                end
            end
            if (pend_q.sel == FSEL_DIS && !fuse_q.wp[WP_DIS]) begin
                fuse_d.dis = fuse_q.dis | pend_q.mask[DIS_W-1:0];
            end
            if (pend_q.sel == FSEL_WP) begin
                fuse_d.wp = fuse_q.wp | pend_q.mask[WP_W-1:0];
            end
            if (pend_q.sel == FSEL_RP) begin
                fuse_d.rp = fuse_q.rp | pend_q.mask[N_SLOTS-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fuse_q <= '0;
        else     fuse_q <= fuse_d;
    end

    assign busy  = pend_v_q;
    assign fuses = fuse_q;

endmodule

// File: rtl/otp_key_select.sv
`timescale 1ns/1ps
module otp_key_select
    import otp_pkg::*;
(
    input  purpose_arr_t      kp,
    output logic [SLOT_W-1:0] slot,
    output logic              valid
);

    logic [N_SLOTS-1:0] hit;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_match
        assign hit[g] = (kp[g] == PURP_W'(KEY_PURPOSE));
    end

    always_comb begin
        slot  = '0;
        valid = |hit;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (hit[i]) slot = SLOT_W'(i);
        end
    end

endmodule

// File: rtl/otp_crypt_status.sv
`timescale 1ns/1ps
module otp_crypt_status
    import otp_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_locked,
    input  logic             manual_dis,
    input  logic             dl_mode,
    output logic             enc_en,
    output logic [FL_W-1:0]  flashes_left
);

    logic odd;

    assign odd          = ^cnt;
    assign enc_en       = odd && !(manual_dis && dl_mode);
    assign flashes_left = cnt_locked ? '0 : plain_left(cnt);

endmodule

// File: rtl/otp_crypt_ctrl.sv
`timescale 1ns/1ps
module otp_crypt_ctrl
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burn_stb,
    input  logic [FSEL_W-1:0] burn_sel,
    input  logic [MASK_W-1:0] burn_mask,
    input  logic [FSEL_W-1:0] rd_sel,
    output logic [RD_W-1:0]   rd_data,
    input  logic              dl_mode,
    output logic              busy,
    output logic              enc_en,
    output logic [SLOT_W-1:0] key_slot,
    output logic              key_valid,
    output logic [FL_W-1:0]   flashes_left,
    output logic              dl_crypt_blocked
);

    fuse_state_t fuses;

    otp_fuse_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .burn_stb  (burn_stb),
        .burn_sel  (burn_sel),
        .burn_mask (burn_mask),
        .busy      (busy),
        .fuses     (fuses)
    );

    otp_key_select u_ksel (
        .kp    (fuses.kp),
        .slot  (key_slot),
        .valid (key_valid)
    );

    otp_crypt_status u_stat (
        .cnt          (fuses.cnt),
        .cnt_locked   (fuses.wp[WP_CNT]),
        .manual_dis   (fuses.dis[DIS_MANUAL]),
        .dl_mode      (dl_mode),
        .enc_en       (enc_en),
        .flashes_left (flashes_left)
    );

    assign dl_crypt_blocked = fuses.dis[DIS_MANUAL];

    always_comb begin
        rd_data = '0;
        if (rd_sel == FSEL_CNT || rd_sel == FSEL_ADV) rd_data[CNT_W-1:0] = fuses.cnt;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (rd_sel == FSEL_W'(FSEL_KP0 + i) && !fuses.rp[i]) begin
                rd_data[PURP_W-1:0] = fuses.kp[i];
            end
        end
        if (rd_sel == FSEL_DIS) rd_data[DIS_W-1:0]   = fuses.dis;
        if (rd_sel == FSEL_WP)  rd_data[WP_W-1:0]    = fuses.wp;
        if (rd_sel == FSEL_RP)  rd_data[N_SLOTS-1:0] = fuses.rp;
    end

endmodule

// File: rtl/otp_crypt_ctrl_chk.sv
`timescale 1ns/1ps
module otp_crypt_ctrl_chk
    import otp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              burn_stb,
    input logic              busy,
    input logic              dl_mode,
    input logic              enc_en,
    input logic              key_valid,
    input logic [SLOT_W-1:0] key_slot,
    input logic [FL_W-1:0]   flashes_left,
    input logic [FSEL_W-1:0] rd_sel,
    input logic [RD_W-1:0]   rd_data,
    input fuse_state_t       fuses
);

    p_cnt_monotonic_r2: assert property (@(posedge clk) disable iff (rst)
        (fuses.cnt & $past(fuses.cnt)) == $past(fuses.cnt));

    p_wp_monotonic_r2: assert property (@(posedge clk) disable iff (rst)
        (fuses.wp & $past(fuses.wp)) == $past(fuses.wp));

    p_even_off_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(fuses.cnt) % 2 == 0) |-> !enc_en);

    p_key_match_r5: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> fuses.kp[key_slot] == PURP_W'(KEY_PURPOSE));

    p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        $past(fuses.wp[WP_CNT]) |-> $stable(fuses.cnt));

    p_dis_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        $past(fuses.wp[WP_DIS]) |-> $stable(fuses.dis));

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_rp
        p_rp_hidden_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_sel == FSEL_W'(FSEL_KP0 + g) && fuses.rp[g]) |-> rd_data == '0);
    end

    p_dl_block_r8: assert property (@(posedge clk) disable iff (rst)
        (fuses.dis[DIS_MANUAL] && dl_mode) |-> !enc_en);

    p_left_locked_r9: assert property (@(posedge clk) disable iff (rst)
        fuses.wp[WP_CNT] |-> flashes_left == '0);

    p_busy_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        (burn_stb && !busy) |=> busy);

endmodule

bind otp_crypt_ctrl otp_crypt_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .burn_stb     (burn_stb),
    .busy         (busy),
    .dl_mode      (dl_mode),
    .enc_en       (enc_en),
    .key_valid    (key_valid),
    .key_slot     (key_slot),
    .flashes_left (flashes_left),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .fuses        (fuses)
);

// File: tb/sim_otp_crypt_ctrl.sv
`timescale 1ns/1ps
module sim_otp_crypt_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       burn_stb = 1'b0;
    logic [3:0] burn_sel = '0;
    logic [7:0] burn_mask = '0;
    logic [3:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       dl_mode = 1'b0;
    logic       busy, enc_en, key_valid, dl_crypt_blocked;
    logic [2:0] key_slot;
    logic [1:0] flashes_left;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0] m_cnt;
    logic [3:0] m_kp [6];
    logic [2:0] m_dis;
    logic [7:0] m_wp;
    logic [5:0] m_rp;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_crypt_ctrl u0 (
        .clk(clk), .rst(rst), .burn_stb(burn_stb), .burn_sel(burn_sel),
        .burn_mask(burn_mask), .rd_sel(rd_sel), .rd_data(rd_data),
        .dl_mode(dl_mode), .busy(busy), .enc_en(enc_en), .key_slot(key_slot),
        .key_valid(key_valid), .flashes_left(flashes_left),
        .dl_crypt_blocked(dl_crypt_blocked)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_clear();
        m_cnt = '0; m_dis = '0; m_wp = '0; m_rp = '0;
        for (int i = 0; i < 6; i++) m_kp[i] = '0;
    endfunction

    function automatic void model_burn(input int f, input logic [7:0] m);
        if (f == 0 && !m_wp[0]) m_cnt |= m[2:0];
        if (f == 1 && !m_wp[0]) begin
            if (!m_cnt[0]) m_cnt[0] = 1'b1;
            else if (!m_cnt[1]) m_cnt[1] = 1'b1;
            else m_cnt[2] = 1'b1;
        end
        if (f >= 2 && f <= 7 && !m_wp[f-1]) m_kp[f-2] |= m[3:0];
        if (f == 8 && !m_wp[7]) m_dis |= m[2:0];
        if (f == 9) m_wp |= m;
        if (f == 10) m_rp |= m[5:0];
    endfunction

    function automatic int exp_read(input int f);
        if (f <= 1) return int'(m_cnt);
        if (f <= 7) return m_rp[f-2] ? 0 : int'(m_kp[f-2]);
        if (f == 8) return int'(m_dis);
        if (f == 9) return int'(m_wp);
        if (f == 10) return int'(m_rp);
        return 0;
    endfunction

    function automatic int exp_left();
        int clear;
        if (m_wp[0]) return 0;
        clear = 0;
        for (int i = 2; i >= 0; i--) begin
            if (m_cnt[i]) break;
            clear++;
        end
        return clear / 2;
    endfunction

    function automatic int exp_slot();
        for (int i = 0; i < 6; i++) if (m_kp[i] == 4'd4) return i;
        return -1;
    endfunction

    task automatic compare_all(input string tag);
        int es;
        bit ee;
        for (int f = 0; f < 12; f++) begin
            @(negedge clk);
            rd_sel = 4'(f);
            #1;
            chk(rd_data == 8'(exp_read(f)), {tag, " R2/R7 read"}, int'(rd_data), exp_read(f));
        end
        ee = ($countones(m_cnt) % 2 == 1) && !(m_dis[0] && dl_mode);
        chk(enc_en == ee, {tag, " R3/R8 enc_en"}, int'(enc_en), int'(ee));
        chk(flashes_left == 2'(exp_left()), {tag, " R9 flashes_left"}, int'(flashes_left), exp_left());
        es = exp_slot();
        chk(key_valid == (es >= 0), {tag, " R5 key_valid"}, int'(key_valid), int'(es >= 0));
        chk(key_slot == 3'((es < 0) ? 0 : es), {tag, " R5 key_slot"}, int'(key_slot), (es < 0) ? 0 : es);
        chk(dl_crypt_blocked == m_dis[0], {tag, " R8 blocked flag"}, int'(dl_crypt_blocked), int'(m_dis[0]));
    endtask

    task automatic do_burn(input int f, input logic [7:0] m, input string tag);
        @(negedge clk);
        burn_stb = 1'b1; burn_sel = 4'(f); burn_mask = m;
        @(negedge clk);
        burn_stb = 1'b0;
        rd_sel = 4'(f);
        #1;
        chk(busy == 1'b1, {tag, " R10 busy high"}, int'(busy), 1);
        chk(rd_data == 8'(exp_read(f)), {tag, " R10 old value while busy"}, int'(rd_data), exp_read(f));
        @(negedge clk);
        model_burn(f, m);
        chk(busy == 1'b0, {tag, " R10 busy low"}, int'(busy), 0);
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(enc_en == 1'b0, "R1 enc_en", int'(enc_en), 0);
        chk(flashes_left == 2'd1, "R1 flashes_left", int'(flashes_left), 1);
        compare_all("R1 reset");

        // R4 advance sequence 001, 011, 111, stay full
        do_burn(1, 8'h00, "R4 adv1");
        chk(enc_en == 1'b1, "R3 enc on at 001", int'(enc_en), 1);
        do_burn(1, 8'h00, "R4 adv2");
        chk(enc_en == 1'b0, "R3 enc off at 011", int'(enc_en), 0);
        do_burn(1, 8'h00, "R4 adv3");
        do_burn(1, 8'h00, "R4 adv full");
        chk(rd_data == 8'h07 || rd_sel != 4'd0, "R4 full stays", int'(m_cnt), 7);

        // R2 raw burn, zero mask, R9 no room above
        do_reset();
        do_burn(0, 8'h02, "R2 raw 010");
        chk(flashes_left == 2'd0, "R9 010 gives 0", int'(flashes_left), 0);
        do_burn(0, 8'h00, "R2 zero mask");
        do_burn(11, 8'hff, "R2 invalid code");

        // R5 priority and fallback
        do_reset();
        do_burn(5, 8'h04, "R5 slot3");
        do_burn(3, 8'h04, "R5 slot1");
        chk(key_slot == 3'd1, "R5 lowest slot", int'(key_slot), 1);
        do_burn(3, 8'h01, "R5 spoil slot1");
        chk(key_slot == 3'd3, "R5 fallback slot3", int'(key_slot), 3);

        // R7 read protect keeps selection
        do_burn(10, 8'h08, "R7 rp slot3");
        chk(key_valid == 1'b1, "R7 still valid", int'(key_valid), 1);

        // R6 write protect slot, counter, group
        do_burn(9, 8'h10, "R6 wp slot3");
        do_burn(5, 8'h08, "R6 burn protected slot3");
        do_burn(9, 8'h01, "R6 wp counter");
        do_burn(1, 8'h00, "R6 adv protected");
        chk(flashes_left == 2'd0, "R9 locked zero", int'(flashes_left), 0);

        // R8 download block, then group protect
        do_reset();
        do_burn(1, 8'h00, "R8 enable");
        do_burn(8, 8'h01, "R8 manual dis");
        dl_mode = 1'b1;
        compare_all("R8 dl on");
        chk(enc_en == 1'b0, "R8 forced off", int'(enc_en), 0);
        dl_mode = 1'b0;
        compare_all("R8 dl off");
        chk(enc_en == 1'b1, "R8 normal boot on", int'(enc_en), 1);
        do_burn(9, 8'h80, "R6 wp group");
        do_burn(8, 8'h06, "R6 group frozen");

        // R10 second strobe during busy is dropped
        do_reset();
        @(negedge clk);
        burn_stb = 1'b1; burn_sel = 4'd2; burn_mask = 8'h04;
        @(negedge clk);
        burn_sel = 4'd3; burn_mask = 8'h04;
        @(negedge clk);
        burn_stb = 1'b0;
        model_burn(2, 8'h04);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R10 no second busy", int'(busy), 0);
        compare_all("R10 drop");

        // random rounds
        for (int r = 0; r < 20; r++) begin
            do_reset();
            dl_mode = 1'($urandom_range(0, 1));
            for (int k = 0; k < 12; k++) begin
                int f;
                logic [7:0] m;
                f = int'($urandom_range(0, 11));
                m = 8'($urandom);
                if (f == 9) m = m & 8'($urandom);
                if (f >= 2 && f <= 7 && $urandom_range(0, 1) == 1) m = 8'h04;
                do_burn(f, m, "RND");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule